// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the run of column addresses that a memory controller presents to an SDRAM row, one address per clock. A request carries a starting column within a 256-column row, a length code and an ordering choice. The block then steps through the burst in that order and marks each cycle that carries an address with a valid strobe. It flags the final beat of a fixed-length burst.

The ordering is either linear or interleaved. A linear burst of 2, 4 or 8 beats counts upward and wraps inside the aligned block of that size. An interleaved burst XORs the beat index into the low column bits. A full-page burst always counts linearly. It wraps from column 255 to column 0 and runs until a stop input ends it. A stop input can also cut a fixed burst short. A new request accepted mid-burst restarts the sequence at once. Data movement, command issue and bank bookkeeping belong to the surrounding controller.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and in the first cycle after its release, `valid_o` and `last_o` are low.
- R2: When `start_i` is sampled high at a clock edge, `valid_o` is high in the next cycle and `col_o` equals the sampled `start_col_i` (beat 0). Each later beat follows one cycle after the previous one.
- R3: Length code `len_code_i` selects the beat count L: 3'd0 gives 1, 3'd1 gives 2, 3'd2 gives 4, 3'd3 gives 8, and 3'd7 gives a full page. Codes 3'd4 to 3'd6 behave as a single beat.
- R4: With `order_i` = 0 (linear) and L of 2, 4 or 8, beat i addresses (S & ~(L-1)) | ((S+i) & (L-1)), where S is the start column.
- R5: With `order_i` = 1 (interleaved) and L of 2, 4 or 8, beat i addresses S XOR i. Only the low log2(L) bits change.
- R6: A full-page burst addresses (S+i) mod 256 at beat i, whatever the value of `order_i`. It keeps `valid_o` high across the 255-to-0 wrap until it is stopped.
- R7: `last_o` is high exactly on beat L-1 of a fixed-length burst and only while `valid_o` is high. Unless a new start is sampled, `valid_o` is low in the following cycle.
- R8: `last_o` never rises during a full-page burst.
- R9: When `stop_i` is sampled high during a burst without `start_i`, `valid_o` is low in the next cycle. When `stop_i` arrives while idle, the outputs stay low.
- R10: When `start_i` is sampled high during an active burst, the next cycle shows beat 0 of the new request, and the new burst runs its full length.
- R11: When `start_i` and `stop_i` are sampled high together, the start takes effect and the stop is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept a new burst request this cycle |
| start_col_i | input | 8 | Starting column of the request |
| len_code_i | input | 3 | Burst length code (see R3) |
| order_i | input | 1 | 0 selects linear order, 1 selects interleaved order |
| stop_i | input | 1 | End the burst in progress after the current beat |
| valid_o | output | 1 | A column address is presented this cycle |
| col_o | output | 8 | Current column address |
| last_o | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
Every cycle, the assertions check the cycle-level rules: a sampled start yields beat 0 at the requested column, beats advance one step at a time until the last beat, a last beat or a stop drops the strobe, a full-page burst carries on until stopped, and a start beats a simultaneous stop. The bench scenarios cover the address arithmetic. They sweep every start column under each fixed length and both orders, walk full pages past the wrap point, and compare each beat with an independently computed column. The bench also checks reserved length codes, a stop while idle, and a mid-burst restart.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int unsigned LEN_CODE_W = 3;

  localparam logic [LEN_CODE_W-1:0] LEN_ONE  = 3'd0;
  localparam logic [LEN_CODE_W-1:0] LEN_TWO  = 3'd1;
  localparam logic [LEN_CODE_W-1:0] LEN_FOUR = 3'd2;
  localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'd3;
  localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'd7;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o
);

  // Mask of the column bits that move during a burst (length - 1).
  function automatic logic [COL_W-1:0] span_mask(input logic [LEN_CODE_W-1:0] code);
    logic [COL_W-1:0] m;
    case (code)
      LEN_TWO:   m = COL_W'(1);
      LEN_FOUR:  m = COL_W'(3);
      LEN_EIGHT: m = COL_W'(7);
      LEN_PAGE:  m = '1;
      default:   m = '0;
    endcase
    return m;
  endfunction

  assign mask_o = span_mask(len_code_i);
  assign full_o = (len_code_i == LEN_PAGE);

endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             order_i,
  input  logic             stop_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_col_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o,
  output logic             last_o
);

  logic             active_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;
  logic             final_beat;

  // Final beat only exists for fixed-length bursts.
  assign final_beat = active_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= start_col_i;
      mask_q   <= mask_i;
      full_q   <= full_i;
      // Full-page bursts are always walked in linear order.
      ilv_q    <= (order_i == ORD_INTERLEAVE) && !full_i;
    end else if (active_q) begin
      if (stop_i || final_beat) begin
        active_q <= 1'b0;
      end else begin
        beat_q <= beat_q + COL_W'(1);
      end
    end
  end

  assign active_o   = active_q;
  assign beat_o     = beat_q;
  assign base_col_o = base_q;
  assign mask_o     = mask_q;
  assign full_o     = full_q;
  assign ilv_o      = ilv_q;
  assign last_o     = final_beat;

endmodule

// File: rtl/bcg_addr_map.sv
module bcg_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_col_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  // Linear: count up inside the aligned block selected by mask.
  function automatic logic [COL_W-1:0] linear_col(
    input logic [COL_W-1:0] base,
    input logic [COL_W-1:0] beat,
    input logic [COL_W-1:0] mask
  );
    logic [COL_W-1:0] sum;
    sum = base + beat;
    return (base & ~mask) | (sum & mask);
  endfunction

  // Interleaved: beat index flips the moving low bits.
  function automatic logic [COL_W-1:0] interleave_col(
    input logic [COL_W-1:0] base,
    input logic [COL_W-1:0] beat,
    input logic [COL_W-1:0] mask
  );
    return base ^ (beat & mask);
  endfunction

  assign col_o = ilv_i ? interleave_col(base_col_i, beat_i, mask_i)
                       : linear_col(base_col_i, beat_i, mask_i);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  input  logic                  stop_i,
  output logic                  valid_o,
  output logic [COL_W-1:0]      col_o,
  output logic                  last_o
);

  logic [COL_W-1:0] req_mask_w;
  logic             req_full_w;
  logic             active_w;
  logic [COL_W-1:0] beat_w;
  logic [COL_W-1:0] base_w;
  logic [COL_W-1:0] mask_w;
  logic             full_w;
  logic             ilv_w;
  logic             last_w;
  logic [COL_W-1:0] col_w;

  bcg_len_decode #(.COL_W(COL_W)) u_dec (
    .len_code_i (len_code_i),
    .mask_o     (req_mask_w),
    .full_o     (req_full_w)
  );

  bcg_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mask_i      (req_mask_w),
    .full_i      (req_full_w),
    .order_i     (order_i),
    .stop_i      (stop_i),
    .active_o    (active_w),
    .beat_o      (beat_w),
    .base_col_o  (base_w),
    .mask_o      (mask_w),
    .full_o      (full_w),
    .ilv_o       (ilv_w),
    .last_o      (last_w)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base_col_i (base_w),
    .beat_i     (beat_w),
    .mask_i     (mask_w),
    .ilv_i      (ilv_w),
    .col_o      (col_w)
  );

  assign valid_o = active_w;
  assign col_o   = col_w;
  assign last_o  = last_w;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic             valid_o,
  input logic [COL_W-1:0] col_o,
  input logic             last_o,
  input logic             full_w,
  input logic [COL_W-1:0] beat_w
);

  // R2 / R10: a sampled start shows beat 0 at the requested column next cycle.
  assert_start_col_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    start_i |=> (valid_o && col_o == $past(start_col_i) && beat_w == '0));

  // R11: start wins over a simultaneous stop.
  assert_start_over_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (start_i && stop_i) |=> valid_o);

  // R7: the last flag appears only on a valid beat.
  assert_last_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    last_o |-> valid_o);

  // R7: after the last beat the strobe drops unless a start arrives.
  assert_last_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (last_o && !start_i) |=> !valid_o);

  // R9: a stop during a burst drops the strobe next cycle.
  assert_stop_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  // R2: beats advance by one each cycle while the burst continues.
  assert_beat_step_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (valid_o && !last_o && !stop_i && !start_i) |=>
      (valid_o && beat_w == $past(beat_w) + COL_W'(1)));

  // R6 / R8: a full page keeps running and never flags a last beat.
  assert_page_runs_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (valid_o && full_w && !stop_i && !start_i) |=> (valid_o && !last_o));

  // R9: with no burst and no start, the strobe stays low.
  assert_idle_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!valid_o && !start_i) |=> !valid_o);

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .valid_o     (valid_o),
  .col_o       (col_o),
  .last_o      (last_o),
  .full_w      (full_w),
  .beat_w      (beat_w)
);

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] start_col;
  logic [2:0] len_code;
  logic       order;
  logic       stop;
  logic       valid;
  logic [7:0] col;
  logic       last;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  burst_col_gen u0 (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .start_i     (start),
    .start_col_i (start_col),
    .len_code_i  (len_code),
    .order_i     (order),
    .stop_i      (stop),
    .valid_o     (valid),
    .col_o       (col),
    .last_o      (last)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int beats_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  // Expected column, computed arithmetically from the requirements.
  function automatic int exp_col(input int s, input int len, input int ord, input int i);
    int base, off;
    base = s - (s % len);
    off  = s % len;
    if (ord == 1) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  task automatic issue(input int s, input int code, input int ord);
    start     = 1'b1;
    start_col = 8'(s);
    len_code  = 3'(code);
    order     = ord[0];
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_fixed(input int s, input int code, input int ord, input string req);
    int len;
    len = beats_of(code);
    issue(s, code, ord);
    for (int i = 0; i < len; i++) begin
      chk({req, " valid"}, valid, 1);
      chk({req, " col"}, col, exp_col(s, len, ord, i));
      chk({"R7 last"}, last, (i == len - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R7 valid drops", valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_col = '0; len_code = '0; order = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", valid, 0);
    chk("R1 last in reset", last, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", valid, 0);
    chk("R1 last after reset", last, 0);

    // R3 R4 R5: every start column, each fixed length and both orders.
    for (int code = 0; code < 4; code++)
      for (int ord = 0; ord < 2; ord++)
        for (int s = 0; s < 256; s++)
          run_fixed(s, code, ord, (ord == 1 && code > 0) ? "R5" : "R4");

    // R3: reserved codes act as a single beat.
    for (int code = 4; code < 7; code++)
      for (int s = 0; s < 256; s += 37)
        run_fixed(s, code, code & 1, "R3");

    // R6 R8: full page across the wrap, order ignored, then stopped.
    for (int k = 0; k < 6; k++) begin
      int s;
      s = (k * 53 + 200) % 256;
      issue(s, 7, k & 1);
      for (int i = 0; i < 300; i++) begin
        chk("R6 valid", valid, 1);
        chk("R6 col", col, (s + i) % 256);
        chk("R8 last", last, 0);
        if (i == 299) stop = 1'b1;
        @(negedge clk);
      end
      stop = 1'b0;
      chk("R9 stop ends page", valid, 0);
    end

    // R9: stop cutting a fixed burst short.
    issue(10, 3, 0);
    chk("R9 beat0", col, 10);
    @(negedge clk);
    chk("R9 beat1", col, 11);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R9 stopped", valid, 0);

    // R9: stop while idle changes nothing.
    stop = 1'b1;
    repeat (3) @(negedge clk);
    stop = 1'b0;
    chk("R9 idle valid", valid, 0);
    chk("R9 idle last", last, 0);
    run_fixed(5, 2, 0, "R9 after idle stop");

    // R10: restart mid-burst with a new column and a new order.
    issue(40, 3, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 before restart", col, 42);
    run_fixed(99, 3, 1, "R10");

    // R11: start and stop together, start wins.
    issue(60, 7, 0);
    @(negedge clk);
    stop = 1'b1;
    issue(130, 2, 1);
    stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R11 valid", valid, 1);
      chk("R11 col", col, exp_col(130, 4, 1, i));
      chk("R11 last", last, (i == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R11 end", valid, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule